// File: doc/BRIEF.md
# Binary32 Round-to-Integral Unit

This unit takes one IEEE 754 binary32 operand and rounds it to a whole number. The result is returned in binary32 format, not as an integer. A 3-bit rounding-mode input picks the direction. An "exact" select chooses between two variants: the plain one, which never reports inexactness, and the exact one, which raises the inexact flag when rounding changed the value.

The unit has one register stage. An operand presented with `in_valid` produces its result and flag vector on the next clock edge, with `out_valid` high for that one cycle. There is no back-pressure, so the unit accepts a new operand every cycle.

Special operands follow fixed rules:
- Zeros, infinities and finite values of magnitude at least 2^23 are already integral and come back unchanged.
- Every NaN returns the canonical quiet NaN.
- An unsupported rounding-mode code forces the canonical NaN together with the invalid flag.

Top module: `fp_round_integral`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle with `in_valid` high and low otherwise; reset clears `out_valid`, `out_res` and `out_flags` to zero.
- R2: Finite non-integral operands are rounded by `in_rm`: 0 nearest-ties-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity, 4 nearest-ties-away-from-zero.
- R3: A zero or infinite operand (either sign) is returned bit-identical with all flags clear, in both variants.
- R4: A finite operand with biased exponent of 150 or more (magnitude at least 2^23) is returned bit-identical with all flags clear.
- R5: Any NaN operand returns 0x7FC00000. A signaling NaN (fraction MSB, bit 22, clear) sets the invalid flag `out_flags[4]`; a quiet NaN sets no flag.
- R6: Rounding-mode codes 5, 6 and 7 return 0x7FC00000 with only `out_flags[4]` set, whatever the operand.
- R7: `out_flags[0]` (inexact) is set only when `in_exact` was high, the operand was not NaN, and the result differs from the operand. With `in_exact` low, only `out_flags[4]` can be raised.
- R8: The sign of the result equals the operand sign for every non-NaN operand, so a negative value rounding to zero gives 0x80000000.
- R9: When rounding carries out of the kept fraction bits, the exponent increments (0.75 up gives 1.0, 8388607.5 to nearest-even gives 2^23).
- R10: `out_flags[3:1]` (divide-by-zero, overflow, underflow) are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_op | input | 32 | Binary32 operand |
| in_rm | input | 3 | Rounding-mode code |
| in_exact | input | 1 | 1 selects the variant that reports inexact |
| out_valid | output | 1 | Result present this cycle |
| out_res | output | 32 | Binary32 integral result |
| out_flags | output | 5 | Flags {invalid, div-by-zero, overflow, underflow, inexact} |

## Verification
Every result and flag vector passes through exactly one register, so an operand applied before a rising edge has its outcome visible right after that edge. That outcome is held until the next edge.

The driver applies operands on the falling edge and queues the expected result computed from the requirements. The monitor checks on the following falling edge, whenever `out_valid` is high, by popping the oldest queued entry. Back-to-back operands therefore line up one-for-one. A leftover or missing entry after the stream drains is reported as a mismatch.

// File: rtl/fp_rti_pkg.sv
package fp_rti_pkg;

    localparam int EXP_W   = 8;
    localparam int MAN_W   = 23;
    localparam int FP_W    = 1 + EXP_W + MAN_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int INT_EXP = BIAS + MAN_W;          // first exponent with no fraction bits
    localparam int FLAG_W  = 5;
    localparam int RM_W    = 3;
    localparam int SH_W    = $clog2(MAN_W + 1);

    localparam int FLG_NV  = 4;
    localparam int FLG_NX  = 0;

    localparam logic [FP_W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    typedef enum logic [RM_W-1:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_ZERO      = 3'd1,
        RM_DOWN      = 3'd2,
        RM_UP        = 3'd3,
        RM_NEAR_MAX  = 3'd4
    } rnd_mode_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
        logic             is_zero;
        logic             is_inf;
        logic             is_nan;
        logic             is_snan;
        logic             is_big;
        logic             is_frac_only;
    } op_info_t;

    typedef struct packed {
        logic              valid;
        logic [FP_W-1:0]   res;
        logic [FLAG_W-1:0] flags;
    } out_stage_t;

endpackage

// File: rtl/rti_unpack.sv
module rti_unpack
    import fp_rti_pkg::*;
(
    input  logic [FP_W-1:0] op,
    output op_info_t        info
);

    logic exp_ones;
    logic exp_none;
    logic man_none;

    always_comb begin
        info.sign = op[FP_W-1];
        info.exp  = op[FP_W-2 -: EXP_W];
        info.man  = op[MAN_W-1:0];

        exp_ones = &info.exp;
        exp_none = ~|info.exp;
        man_none = ~|info.man;

        info.is_zero      = exp_none & man_none;
        info.is_inf       = exp_ones & man_none;
        info.is_nan       = exp_ones & ~man_none;
        info.is_snan      = info.is_nan & ~info.man[MAN_W-1];
        info.is_big       = ~exp_ones & (info.exp >= EXP_W'(INT_EXP));
        info.is_frac_only = ~info.is_zero & (info.exp < EXP_W'(BIAS));
    end

endmodule

// File: rtl/rti_core.sv
module rti_core
    import fp_rti_pkg::*;
(
    input  logic             sign,
    input  logic [EXP_W-1:0] exp,
    input  logic [MAN_W-1:0] man,
    input  logic             frac_only,
    input  logic [RM_W-1:0]  rm,
    output logic [FP_W-1:0]  res,
    output logic             inexact
);

    logic [SH_W-1:0]   sh;
    logic [MAN_W:0]    mant;
    logic [MAN_W:0]    one_hot;
    logic [MAN_W:0]    low_mask;
    logic [FP_W-2:0]   trunc;
    logic [FP_W-2:0]   step;
    logic [FP_W-2:0]   mag;
    logic              rbit;
    logic              sticky;
    logic              lsb;
    logic              inc;

    always_comb begin
        // number of fraction bits still inside the significand (1..23)
        sh       = SH_W'(INT_EXP) - exp[SH_W-1:0];
        mant     = {1'b1, man};
        one_hot  = {{MAN_W{1'b0}}, 1'b1} << sh;
        low_mask = one_hot - 1'b1;

        if (frac_only) begin
            // magnitude below one: integer part is zero
            rbit   = (exp == EXP_W'(BIAS - 1));
            sticky = rbit ? (|man) : 1'b1;
            lsb    = 1'b0;
        end else begin
            rbit   = |(mant & (one_hot >> 1));
            sticky = |(mant & (low_mask >> 1));
            lsb    = |(mant & one_hot);
        end

        case (rm)
            RM_NEAR_EVEN: inc = rbit & (sticky | lsb);
            RM_ZERO:      inc = 1'b0;
            RM_DOWN:      inc = sign & (rbit | sticky);
            RM_UP:        inc = ~sign & (rbit | sticky);
            RM_NEAR_MAX:  inc = rbit;
            default:      inc = 1'b0;
        endcase

        trunc = {exp, man} & ~{{EXP_W{1'b0}}, low_mask[MAN_W-1:0]};
        step  = {{(EXP_W-1){1'b0}}, one_hot};

        if (frac_only)
            mag = inc ? {EXP_W'(BIAS), {MAN_W{1'b0}}} : '0;
        else
            mag = trunc + (inc ? step : '0);   // carry may ripple into exponent

        res     = {sign, mag};
        inexact = rbit | sticky;
    end

endmodule

// File: rtl/fp_round_integral.sv
module fp_round_integral
    import fp_rti_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [FP_W-1:0]     in_op,
    input  logic [RM_W-1:0]     in_rm,
    input  logic                in_exact,
    output logic                out_valid,
    output logic [FP_W-1:0]     out_res,
    output logic [FLAG_W-1:0]   out_flags
);

    op_info_t        info;
    logic [FP_W-1:0] core_res;
    logic            core_inexact;
    logic            mode_bad;
    out_stage_t      st_d;
    out_stage_t      st_q;

    rti_unpack u_unpack (
        .op   (in_op),
        .info (info)
    );

    rti_core u_core (
        .sign      (info.sign),
        .exp       (info.exp),
        .man       (info.man),
        .frac_only (info.is_frac_only),
        .rm        (in_rm),
        .res       (core_res),
        .inexact   (core_inexact)
    );

    always_comb begin
        mode_bad    = in_rm > RM_NEAR_MAX;
        st_d        = st_q;
        st_d.valid  = in_valid;
        if (in_valid) begin
            st_d.flags = '0;
            if (mode_bad) begin
                st_d.res           = CANON_NAN;
                st_d.flags[FLG_NV] = 1'b1;
            end else if (info.is_nan) begin
                st_d.res           = CANON_NAN;
                st_d.flags[FLG_NV] = info.is_snan;
            end else if (info.is_zero || info.is_inf || info.is_big) begin
                st_d.res           = in_op;
            end else begin
                st_d.res           = core_res;
                st_d.flags[FLG_NX] = in_exact & core_inexact;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_res   = st_q.res;
    assign out_flags = st_q.flags;

endmodule

// File: rtl/fp_round_integral_chk.sv
module fp_round_integral_chk
    import fp_rti_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [FP_W-1:0]   in_op,
    input logic [RM_W-1:0]   in_rm,
    input logic              in_exact,
    input logic              out_valid,
    input logic [FP_W-1:0]   out_res,
    input logic [FLAG_W-1:0] out_flags
);

    logic op_exp_ones, op_man_none, op_nan, op_zero_inf, op_big, rm_ok;

    always_comb begin
        op_exp_ones = &in_op[FP_W-2 -: EXP_W];
        op_man_none = ~|in_op[MAN_W-1:0];
        op_nan      = op_exp_ones & ~op_man_none;
        op_zero_inf = op_man_none & (op_exp_ones | ~|in_op[FP_W-2 -: EXP_W]);
        op_big      = ~op_exp_ones & (in_op[FP_W-2 -: EXP_W] >= EXP_W'(INT_EXP));
        rm_ok       = in_rm <= 3'd4;
    end

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r3_special_pass: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && rm_ok && op_zero_inf |=> out_res == $past(in_op) && out_flags == '0);
    a_r4_big_pass: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && rm_ok && op_big |=> out_res == $past(in_op) && out_flags == '0);
    a_r5_nan_canon: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_nan |=> out_res == CANON_NAN);
    a_r6_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !rm_ok |=> out_res == CANON_NAN && out_flags == 5'b10000);
    a_r7_plain_no_nx: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_exact |=> !out_flags[FLG_NX]);
    a_r8_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && rm_ok && !op_nan |=> out_res[FP_W-1] == $past(in_op[FP_W-1]));
    a_r10_no_other_flags: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_flags[3:1] == 3'b000);

endmodule

bind fp_round_integral fp_round_integral_chk u_chk (.*);

// File: tb/fp_round_integral_bench.sv
module fp_round_integral_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] res;
        logic [4:0]  flags;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_op = '0;
    logic [2:0]  in_rm = '0;
    logic        in_exact = 1'b0;
    logic        out_valid;
    logic [31:0] out_res;
    logic [4:0]  out_flags;

    exp_t sb[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_round_integral u_fp_round_integral (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_rm(in_rm), .in_exact(in_exact), .out_valid(out_valid),
        .out_res(out_res), .out_flags(out_flags)
    );

    task automatic check(input bit ok, input string tag, input logic [36:0] act, input logic [36:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic send(input logic [31:0] op, input logic [2:0] rm, input logic ex,
                        input logic [31:0] er, input logic [4:0] ef, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_rm = rm; in_exact = ex;
        e.res = er; e.flags = ef; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // monitor: results are due one edge after the operand
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1 unexpected out_valid", {out_flags, out_res}, '0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_res == e.res && out_flags == e.flags, e.tag,
                      {out_flags, out_res}, {e.flags, e.res});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            check(1'b0, "watchdog", '0, '0);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_res == '0 && out_flags == '0, "R1 reset state",
              {out_flags, out_res}, '0);
        rst_n = 1'b1;

        // R2 modes on 1.5 and +/-2.5 (exact variant -> inexact bit0)
        send(32'h3FC00000, 3'd0, 1'b1, 32'h40000000, 5'b00001, "R2 1.5 RNE");
        send(32'h3FC00000, 3'd1, 1'b1, 32'h3F800000, 5'b00001, "R2 1.5 RTZ");
        send(32'h3FC00000, 3'd2, 1'b1, 32'h3F800000, 5'b00001, "R2 1.5 RDN");
        send(32'h3FC00000, 3'd3, 1'b1, 32'h40000000, 5'b00001, "R2 1.5 RUP");
        send(32'h40200000, 3'd0, 1'b1, 32'h40000000, 5'b00001, "R2 2.5 RNE tie even");
        send(32'h40200000, 3'd4, 1'b1, 32'h40400000, 5'b00001, "R2 2.5 RMM");
        send(32'hC0200000, 3'd2, 1'b1, 32'hC0400000, 5'b00001, "R2 -2.5 RDN");
        send(32'hC0200000, 3'd3, 1'b1, 32'hC0000000, 5'b00001, "R2 -2.5 RUP");
        send(32'h3F000000, 3'd4, 1'b1, 32'h3F800000, 5'b00001, "R2 0.5 RMM");
        send(32'h00000001, 3'd3, 1'b1, 32'h3F800000, 5'b00001, "R2 subnormal RUP");
        // R9 exponent carry
        send(32'h3F400000, 3'd3, 1'b1, 32'h3F800000, 5'b00001, "R9 0.75 RUP");
        send(32'h4AFFFFFF, 3'd0, 1'b1, 32'h4B000000, 5'b00001, "R9 8388607.5 RNE");
        // R8 sign on zero result
        send(32'hBE99999A, 3'd1, 1'b1, 32'h80000000, 5'b00001, "R8 -0.3 RTZ");
        send(32'hBE99999A, 3'd3, 1'b0, 32'h80000000, 5'b00000, "R8 -0.3 RUP");
        send(32'hBE99999A, 3'd2, 1'b1, 32'hBF800000, 5'b00001, "R8 -0.3 RDN");
        send(32'h3F000000, 3'd0, 1'b1, 32'h00000000, 5'b00001, "R8 0.5 RNE to +0");
        // R7 exact vs plain, integral input
        send(32'h3FC00000, 3'd0, 1'b0, 32'h40000000, 5'b00000, "R7 plain no NX");
        send(32'h40400000, 3'd0, 1'b1, 32'h40400000, 5'b00000, "R7 integral no NX");
        // R3 / R4 passthrough
        send(32'h7F800000, 3'd0, 1'b1, 32'h7F800000, 5'b00000, "R3 +inf");
        send(32'hFF800000, 3'd2, 1'b1, 32'hFF800000, 5'b00000, "R3 -inf");
        send(32'h80000000, 3'd3, 1'b1, 32'h80000000, 5'b00000, "R3 -0");
        send(32'h4B000001, 3'd3, 1'b1, 32'h4B000001, 5'b00000, "R4 2^23+1");
        send(32'hFF7FFFFF, 3'd4, 1'b1, 32'hFF7FFFFF, 5'b00000, "R4 -max");
        // R5 NaNs
        send(32'h7F800001, 3'd0, 1'b1, 32'h7FC00000, 5'b10000, "R5 sNaN");
        send(32'hFFC00001, 3'd0, 1'b1, 32'h7FC00000, 5'b00000, "R5 qNaN");
        send(32'hFF800002, 3'd1, 1'b0, 32'h7FC00000, 5'b10000, "R5 sNaN plain");
        // R6 bad modes
        send(32'h3F800000, 3'd5, 1'b1, 32'h7FC00000, 5'b10000, "R6 mode 5");
        send(32'h7F800000, 3'd7, 1'b0, 32'h7FC00000, 5'b10000, "R6 mode 7");
        send(32'h3FC00000, 3'd6, 1'b1, 32'h7FC00000, 5'b10000, "R6 mode 6 R10");

        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 idle after stream", {36'b0, out_valid}, '0);
        check(sb.size() == 0, "R1 queue drained", 37'(sb.size()), '0);
        done = 1'b1;
        finish_run();
    end

endmodule